// File: doc/BRIEF.md
# Dual-Mode Recoded Multiply-Add Datapath

This block is the combinational multiply-add core of a high-radix (512) digit-recurrence divider. It has two modes, picked by one input bit. In scaling mode it multiplies a wide operand by a 15-bit two's-complement scale factor. In recurrence mode it multiplies the same operand, normally the divisor, by an 11-bit signed quotient digit. It also adds the carry-save residual, shifted left by nine bit positions. The result is a sum/carry word pair. A carry-propagate adder outside this block resolves that pair. The result registers and the quotient selection are also outside this block.

The multiplier is recoded into radix-4 signed digits. Each digit selects zero, one or two times the operand, and the sign can be inverted. A negative multiple is formed as the one's complement of the magnitude. The missing +1 ("hot one") goes into a separate ninth addend at the digit's weight. Eight partial-product slots plus the hot-one word feed a 9-to-2 carry-save tree.

In recurrence mode the quotient digit yields only six non-zero digits. The two top slots are then reused for the shifted residual sum and carry words. This lets one tree serve both operations. All arithmetic is modulo 2^W.

Top module: `mad_recoded_muladd`

## Requirements
- R1: With `mode_i`=0, `sum_o`+`carry_o` mod 2^W equals `mcand_i` times the sign-extended `scale_m_i` (two's complement, 15 bits), mod 2^W.
- R2: With `mode_i`=1, `sum_o`+`carry_o` mod 2^W equals `mcand_i` times the sign-extended `qdig_i` (two's complement, 11 bits), plus 512·(`rsum_i`+`rcarry_i`), all mod 2^W.
- R3: With `mode_i`=0, the values on `rsum_i`, `rcarry_i` and `qdig_i` have no effect on `sum_o`+`carry_o`.
- R4: With `mode_i`=1, the value on `scale_m_i` has no effect on `sum_o`+`carry_o`.
- R5: Every recoded digit is in {-2,-1,0,+1,+2}. It selects at most one of the operand or twice the operand, and a negative sign occurs only with a non-zero magnitude. Both extreme multipliers, -16384 and +16383, give exact products.
- R6: Negative digits are formed as one's complement plus a hot one at bit 2i for digit i. A multiplier of -1 therefore yields the exact negation of `mcand_i`.
- R7: Results wrap modulo 2^W. Product bits and shifted residual bits above bit W-1 are discarded.
- R8: Quotient digits at the extremes, -1024 and +1023, give exact products in recurrence mode.
- R9: A zero multiplier gives a total of zero in scaling mode. A zero digit in recurrence mode gives exactly the shifted residual.
- R10: In recurrence mode the recoded digits 6 and 7 are zero, and the carry-save tree conserves the arithmetic sum of its nine addends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 1 | 0 = scaling multiply, 1 = recurrence multiply-add |
| mcand_i | input | W | Multiplicand (divisor or operand), taken modulo 2^W |
| scale_m_i | input | 15 | Two's-complement scale multiplier (scaling mode) |
| qdig_i | input | 11 | Two's-complement quotient digit (recurrence mode) |
| rsum_i | input | W-9 | Residual sum word before the radix shift |
| rcarry_i | input | W-9 | Residual carry word before the radix shift |
| sum_o | output | W | Carry-save sum word of the result |
| carry_o | output | W | Carry-save carry word of the result |

## Verification
The bench builds two copies of the block: one at the default width of 64 bits and one at 20 bits. The 64-bit copy covers the full product of a wide divisor by both multiplier kinds, including the negative-digit hot ones in every slot. The 20-bit copy makes wraparound routine. Its products and shifted residuals overflow the word on nearly every vector, so bits dropped above the top position are exercised both randomly and at the multiplier extremes.

// File: rtl/mad_pkg.sv
// Shared types and helpers for the recoded multiply-add datapath.
// Assumes radix-4 recoding with overlapping bit triples.
package mad_pkg;

    // One radix-4 signed digit: sign plus one-hot magnitude select
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } bdig_t;

    // Map a bit triple {y(2i+1), y(2i), y(2i-1)} to a signed digit
    function automatic bdig_t booth_enc(input logic [2:0] trip);
        bdig_t d;
        d = '0;
        unique case (trip)
            3'b001, 3'b010: d.one = 1'b1;
            3'b011:         d.two = 1'b1;
            3'b100:         begin d.neg = 1'b1; d.two = 1'b1; end
            3'b101, 3'b110: begin d.neg = 1'b1; d.one = 1'b1; end
            default:        d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mad_booth_rec.sv
// Radix-4 recoder. Selects the scale multiplier or the quotient digit,
// sign-extends it to an even bit count and emits NDIG signed digits.
// Assumes 2*NDIG >= QB and that the quotient digit is narrower than
// the scale multiplier.
module mad_booth_rec
    import mad_pkg::*;
#(
    parameter int MB = 15,
    parameter int QB = 11,
    localparam int NDIG = (MB + 1) / 2,
    localparam int NQD  = (QB + 1) / 2
) (
    input  logic                     mode_i,
    input  logic [MB-1:0]            scale_m_i,
    input  logic [QB-1:0]            qdig_i,
    output bdig_t [NDIG-1:0]         dig_o
);

    localparam int YB = 2 * NDIG;

    logic [YB:0] ybits;

    // Pick the active multiplier and append the implicit zero below bit 0
    always_comb begin
        if (mode_i)
            ybits = {{(YB - QB){qdig_i[QB-1]}}, qdig_i, 1'b0};
        else
            ybits = {{(YB - MB){scale_m_i[MB-1]}}, scale_m_i, 1'b0};
    end

    // One encoder per overlapping triple
    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        assign dig_o[i] = booth_enc(ybits[2*i+2 : 2*i]);
    end

    // Digit legality and unused-digit checks
    always_comb begin
        for (int i = 0; i < NDIG; i++) begin
            // R5
            digit_sel_chk: assert ($onehot0({dig_o[i].one, dig_o[i].two}));
            // R5
            digit_negnz_chk: assert (!dig_o[i].neg || dig_o[i].one || dig_o[i].two);
            // R10
            upper_zero_chk: assert (!(mode_i && i >= NQD) || dig_o[i] == '0);
        end
    end

endmodule

// File: rtl/mad_pp_gen.sv
// Partial-product generator for digit IDX. Produces the selected
// multiple (one's complement if negative) shifted by 2*IDX, plus the
// hot-one bit the tree must add at weight 2^(2*IDX).
// Assumes 2*IDX < W.
module mad_pp_gen
    import mad_pkg::*;
#(
    parameter int W   = 64,
    parameter int IDX = 0
) (
    input  logic [W-1:0] mcand_i,
    input  bdig_t        dig_i,
    output logic [W-1:0] pp_o,
    output logic         hot_o
);

    logic [W-1:0] mag;

    // Select 0, a or 2a, invert if negative, then align to the digit weight
    always_comb begin
        if (dig_i.two)
            mag = {mcand_i[W-2:0], 1'b0};
        else if (dig_i.one)
            mag = mcand_i;
        else
            mag = '0;
        pp_o  = (dig_i.neg ? ~mag : mag) << (2 * IDX);
        hot_o = dig_i.neg;
    end

endmodule

// File: rtl/mad_csa.sv
// 3:2 carry-save adder over W bits; the carry word is pre-shifted.
// Assumes wraparound modulo 2^W is acceptable.
module mad_csa #(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] s_o,
    output logic [W-1:0] c_o
);

    logic [W-1:0] maj;

    // Bitwise full-adder sum and majority carry
    always_comb begin
        s_o = a_i ^ b_i ^ c_i;
        maj = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
        c_o = maj << 1;
    end

    // Each compressor preserves the arithmetic total
    always_comb begin
        // R10
        csa_conserve_chk: assert (W'(s_o + c_o) == W'(a_i + b_i + c_i));
    end

endmodule

// File: rtl/mad_csa9.sv
// Nine-operand carry-save reduction tree (9 -> 6 -> 4 -> 3 -> 2),
// four full-adder levels deep. Assumes exactly nine W-bit addends.
module mad_csa9 #(
    parameter int W = 64
) (
    input  logic [8:0][W-1:0] ops_i,
    output logic [W-1:0]      sum_o,
    output logic [W-1:0]      carry_o
);

    logic [2:0][W-1:0] l1_s, l1_c;
    logic [W-1:0] l2_s0, l2_c0, l2_s1, l2_c1, l3_s, l3_c;

    // Level 1: three compressors on consecutive operand triples
    for (genvar g = 0; g < 3; g++) begin : g_l1
        mad_csa #(.W(W)) u_csa (
            .a_i(ops_i[3*g]), .b_i(ops_i[3*g+1]), .c_i(ops_i[3*g+2]),
            .s_o(l1_s[g]), .c_o(l1_c[g])
        );
    end

    // Level 2: six words to four
    mad_csa #(.W(W)) u_l2a (
        .a_i(l1_s[0]), .b_i(l1_c[0]), .c_i(l1_s[1]),
        .s_o(l2_s0), .c_o(l2_c0)
    );
    mad_csa #(.W(W)) u_l2b (
        .a_i(l1_c[1]), .b_i(l1_s[2]), .c_i(l1_c[2]),
        .s_o(l2_s1), .c_o(l2_c1)
    );

    // Level 3: four words to three
    mad_csa #(.W(W)) u_l3 (
        .a_i(l2_s0), .b_i(l2_c0), .c_i(l2_s1),
        .s_o(l3_s), .c_o(l3_c)
    );

    // Level 4: three words to the final pair
    mad_csa #(.W(W)) u_l4 (
        .a_i(l3_s), .b_i(l3_c), .c_i(l2_c1),
        .s_o(sum_o), .c_o(carry_o)
    );

endmodule

// File: rtl/mad_recoded_muladd.sv
// Dual-mode recoded multiply-add. Scaling mode: mcand * scale_m.
// Recurrence mode: mcand * qdig + (rsum + rcarry) << RSH, with the two
// slots above the quotient digits reused for the residual words.
// Output is an unresolved carry-save pair, modulo 2^W.
// Assumes W >= 2*NDIG and that the quotient yields at most NDIG-2 digits.
module mad_recoded_muladd
    import mad_pkg::*;
#(
    parameter int W   = 64,
    parameter int MB  = 15,
    parameter int QB  = 11,
    parameter int RSH = 9,
    localparam int NDIG = (MB + 1) / 2,
    localparam int NQD  = (QB + 1) / 2,
    localparam int RW   = W - RSH
) (
    input  logic          mode_i,
    input  logic [W-1:0]  mcand_i,
    input  logic [MB-1:0] scale_m_i,
    input  logic [QB-1:0] qdig_i,
    input  logic [RW-1:0] rsum_i,
    input  logic [RW-1:0] rcarry_i,
    output logic [W-1:0]  sum_o,
    output logic [W-1:0]  carry_o
);

    bdig_t [NDIG-1:0]      dig;
    logic  [NDIG-1:0][W-1:0] pp;
    logic  [NDIG-1:0]      hot;
    logic  [8:0][W-1:0]    ops;
    logic  [W-1:0]         hot_word;
    logic  [W-1:0]         rs_sh, rc_sh;

    mad_booth_rec #(.MB(MB), .QB(QB)) u_rec (
        .mode_i(mode_i), .scale_m_i(scale_m_i), .qdig_i(qdig_i), .dig_o(dig)
    );

    // One multiple generator per digit
    for (genvar i = 0; i < NDIG; i++) begin : g_pp
        mad_pp_gen #(.W(W), .IDX(i)) u_pp (
            .mcand_i(mcand_i), .dig_i(dig[i]), .pp_o(pp[i]), .hot_o(hot[i])
        );
    end

    // Radix shift of the residual words
    assign rs_sh = {rsum_i, {RSH{1'b0}}};
    assign rc_sh = {rcarry_i, {RSH{1'b0}}};

    // Slot assignment: residual words displace the two unused top digits
    for (genvar i = 0; i < NDIG; i++) begin : g_slot
        if (i == NQD) begin : g_rs
            assign ops[i] = mode_i ? rs_sh : pp[i];
        end else if (i == NQD + 1) begin : g_rc
            assign ops[i] = mode_i ? rc_sh : pp[i];
        end else begin : g_pl
            assign ops[i] = pp[i];
        end
    end

    // Gather hot ones at even bit positions into the ninth addend
    always_comb begin
        hot_word = '0;
        for (int i = 0; i < NDIG; i++)
            hot_word[2*i] = hot[i];
    end
    assign ops[8] = hot_word;

    mad_csa9 #(.W(W)) u_tree (
        .ops_i(ops), .sum_o(sum_o), .carry_o(carry_o)
    );

    logic [W-1:0] op_total;

    // Tree output must equal the plain sum of all nine addends
    always_comb begin
        op_total = '0;
        for (int k = 0; k < 9; k++)
            op_total = op_total + ops[k];
        // R10
        tree_total_chk: assert (W'(sum_o + carry_o) == op_total);
        // R6
        hot_even_chk: assert ((hot_word & {(W/2){2'b10}}) == '0);
    end

endmodule

// File: tb/mad_recoded_muladd_test.sv
module mad_recoded_muladd_test;

    localparam int WN = 20;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        mode;
    logic [63:0] a;
    logic [14:0] m;
    logic [10:0] q;
    logic [54:0] rs, rc;
    logic [63:0] s64, c64;
    logic [WN-1:0] sn, cn;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    mad_recoded_muladd uut (
        .mode_i(mode), .mcand_i(a), .scale_m_i(m), .qdig_i(q),
        .rsum_i(rs), .rcarry_i(rc), .sum_o(s64), .carry_o(c64)
    );

    mad_recoded_muladd #(.W(WN)) uut_n (
        .mode_i(mode), .mcand_i(a[WN-1:0]), .scale_m_i(m), .qdig_i(q),
        .rsum_i(rs[WN-10:0]), .rcarry_i(rc[WN-10:0]), .sum_o(sn), .carry_o(cn)
    );

    // Expected total, computed from R1/R2 and masked to w bits (R7)
    function automatic logic [63:0] ref_val(input int w, input logic md,
        input logic [63:0] av, input logic [14:0] mv, input logic [10:0] qv,
        input logic [63:0] rsv, input logic [63:0] rcv);
        logic [63:0] mul, r, msk;
        mul = md ? {{53{qv[10]}}, qv} : {{49{mv[14]}}, mv};
        r = av * mul;
        if (md) r = r + (rsv << 9) + (rcv << 9);
        msk = (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
        return r & msk;
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive one vector, let it settle, compare both widths
    task automatic apply(input string req, input logic md, input logic [63:0] av,
        input logic [14:0] mv, input logic [10:0] qv, input logic [54:0] rsv,
        input logic [54:0] rcv);
        logic [63:0] e64, en;
        @(negedge clk);
        mode = md; a = av; m = mv; q = qv; rs = rsv; rc = rcv;
        #1;
        e64 = ref_val(64, md, av, mv, qv, {9'd0, rsv}, {9'd0, rcv});
        en  = ref_val(WN, md, av, mv, qv, {53'd0, rsv[WN-10:0]}, {53'd0, rcv[WN-10:0]});
        check(req, s64 + c64, e64);
        check({req, " narrow"}, {44'd0, WN'(sn + cn)}, en);
    endtask

    function automatic logic [63:0] r64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        logic [63:0] t;
        void'($urandom(32'h5eed_1234));
        mode = 0; a = '0; m = '0; q = '0; rs = '0; rc = '0;
        repeat (2) @(posedge clk);
        // Idle state: all-zero inputs give a zero total (R9)
        apply("R9 idle", 0, 64'd0, 15'd0, 11'd0, 55'd0, 55'd0);
        apply("R9 zero scale", 0, r64(), 15'd0, 11'd0, 55'd0, 55'd0);
        apply("R9 zero digit", 1, r64(), 15'h1234, 11'd0, r64()[54:0], r64()[54:0]);
        apply("R6 minus one", 0, 64'h0123_4567_89ab_cdef, 15'h7fff, 11'd0, 55'd0, 55'd0);
        apply("R5 min scale", 0, 64'hfedc_ba98_7654_3210, 15'h4000, 11'd0, 55'd0, 55'd0);
        apply("R5 max scale", 0, 64'hffff_ffff_ffff_ffff, 15'h3fff, 11'd0, 55'd0, 55'd0);
        apply("R5 alternating", 0, 64'h8000_0000_0000_0001, 15'h5555, 11'd0, 55'd0, 55'd0);
        apply("R8 min digit", 1, 64'h8765_4321_0fed_cba9, 15'd0, 11'h400, r64()[54:0], r64()[54:0]);
        apply("R8 max digit", 1, 64'h7fff_ffff_ffff_ffff, 15'd0, 11'h3ff, 55'h7f_ffff_ffff_ffff, 55'h7f_ffff_ffff_ffff);
        apply("R7 wrap", 0, 64'hffff_ffff_ffff_ffff, 15'h2aab, 11'd0, 55'd0, 55'd0);
        apply("R7 residual wrap", 1, 64'd0, 15'd0, 11'd0, 55'h7f_ffff_ffff_ffff, 55'h40_0000_0000_0001);
        apply("R6 digit minus one", 1, r64(), 15'd0, 11'h7ff, 55'd0, 55'd0);
        // Ignored inputs: same expectation whatever the idle operands hold (R3, R4)
        t = r64();
        apply("R3 residual ignored", 0, t, 15'h0b3d, 11'h3a5, r64()[54:0], r64()[54:0]);
        apply("R4 scale ignored", 1, t, 15'h7abc, 11'h1c3, r64()[54:0], r64()[54:0]);
        for (int i = 0; i < 400; i++)
            apply("R1 random", 0, r64(), 15'($urandom()), 11'($urandom()), r64()[54:0], r64()[54:0]);
        for (int i = 0; i < 400; i++)
            apply("R2 random", 1, r64(), 15'($urandom()), 11'($urandom()), r64()[54:0], r64()[54:0]);
        for (int i = 0; i < 50; i++)
            apply("R10 random", 1, r64(), 15'($urandom()), 11'($urandom() | 32'h400), r64()[54:0], r64()[54:0]);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule